// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from up to 26 peripheral source lines of a small 8-bit microcontroller. It turns each rising edge on a source into a latched "posted" flag. A per-source mask turns a posted flag into a pending one, and a global enable from the CPU gates delivery. A fixed-priority encoder picks the lowest-numbered pending source. The controller then presents its index, together with a vector address equal to four times that index.

When the CPU acknowledges, the posted flag of the delivered source is cleared. Software reaches the controller over a simple register bus. On that bus it can read and write the mask bytes, read the posted status, clear posted flags one bit at a time, or clear all of them with a single write. Slots with no source behind them are fixed at zero.

Register map: address k (0..3) is mask byte k, and address 4+k is the clear byte k on write and the posted-status byte k on read. Address 8 is the clear-all register. Bit n of byte k belongs to source 8k+n. Any other address reads as 0 and ignores writes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A 0-to-1 transition of an implemented source input, sampled on the clock, sets that source's posted flag on that clock edge. The flag is visible in the status byte and in the request outputs from the following cycle.
- R2: Posting is edge-triggered. A source held high after its flag has been cleared does not set the flag again until it falls and rises again.
- R3: A source is pending only when its posted flag and its mask bit are both 1. Clearing a mask bit neither clears a posted flag nor stops new posting.
- R4: irq_req_o is 1 only when gie_i is 1 and some source is pending. While irq_req_o is 0, irq_idx_o and irq_vec_o are 0.
- R5: With several sources pending, irq_idx_o is the lowest pending index (index 0 is the highest priority).
- R6: irq_vec_o equals irq_idx_o multiplied by 4, for example 0x0014 for index 5 and 0x0064 for index 25.
- R7: Only indices 1, 3, 4, 5, 6, 7, 13, 14, 17, 18, 20 and 25 can post. The posted flags of all other indices, including 0, always read 0 and never raise a request.
- R8: When irq_ack_i is 1 while irq_req_o is 1, the posted flag of the current irq_idx_o is cleared on that edge. irq_req_o falls in the next cycle unless another source is pending.
- R9: Writing clear byte k (address 4+k) clears posted flag 8k+n for each data bit n that is 1. Data bits that are 0 leave their flags unchanged.
- R10: Any write to address 8 clears every posted flag.
- R11: If a new source edge coincides with a clear (by byte, clear-all or acknowledge) of the same flag, the flag ends up set.
- R12: A read (bus_valid_i=1, bus_rd_wrn_i=1) returns the addressed mask or status byte on bus_rdata_o after the next clock edge, which holds its value until the next read. Writes (bus_rd_wrn_i=0) take effect on the edge where bus_valid_i is 1. Mask bits read back as written.
- R13: After reset, all posted flags, mask bits and bus_rdata_o are 0, and irq_req_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 26 | Peripheral request lines, one per priority index |
| gie_i | input | 1 | Global interrupt enable from the CPU |
| irq_ack_i | input | 1 | CPU acknowledge of the presented request |
| irq_req_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 16 | Vector address (index times 4) |
| irq_idx_o | output | 5 | Index of the selected source |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_rd_wrn_i | input | 1 | 1 for a read, 0 for a write |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |

## Verification
A source edge or a bus write lands in the registered state on the rising edge that samples it. irq_req_o, irq_idx_o and irq_vec_o follow combinationally from that state and from the current gie_i, so they are due in the cycle right after the edge. Read data is due after one edge. The bench changes inputs on the falling edge and checks all outputs 2 ns later against a reference model. The model advances exactly once per rising edge, from the same inputs the design sampled, so every check falls in the cycle where the result is due.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Priority slots that have a maskable source behind them.
    localparam logic [25:0] IRQC_IMPL_DEFAULT = 26'h21660FA;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_READ,
        BUS_WRITE
    } bus_op_e;

    function automatic bus_op_e decode_op(input logic valid, input logic rd_wrn);
        if (!valid) return BUS_IDLE;
        return rd_wrn ? BUS_READ : BUS_WRITE;
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 26,
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bus_valid_i,
    input  logic               bus_rd_wrn_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    input  logic [NUM_SRC-1:0] posted_i,
    output logic [DATA_W-1:0]  bus_rdata_o,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] clr_o
);

    localparam int NBYTES      = (NUM_SRC + DATA_W - 1) / DATA_W;
    localparam int CLR_BASE    = NBYTES;
    localparam int CLRALL_ADDR = 2 * NBYTES;

    typedef struct packed {
        logic [NUM_SRC-1:0] mask;
        logic [DATA_W-1:0]  rdata;
    } regs_t;

    regs_t   q, d;
    bus_op_e op;

    always_comb begin
        d     = q;
        clr_o = '0;
        op    = decode_op(bus_valid_i, bus_rd_wrn_i);

        if (op == BUS_WRITE) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (bus_addr_i == ADDR_W'(i / DATA_W)) begin
                    d.mask[i] = bus_wdata_i[i % DATA_W];
                end
                if (bus_addr_i == ADDR_W'(CLR_BASE + i / DATA_W) &&
                    bus_wdata_i[i % DATA_W]) begin
                    clr_o[i] = 1'b1;
                end
            end
            if (bus_addr_i == ADDR_W'(CLRALL_ADDR)) begin
                clr_o = '1;
            end
        end

        if (op == BUS_READ) begin
            d.rdata = '0;
            for (int i = 0; i < NUM_SRC; i++) begin
                if (bus_addr_i == ADDR_W'(i / DATA_W)) begin
                    d.rdata[i % DATA_W] = q.mask[i];
                end
                if (bus_addr_i == ADDR_W'(CLR_BASE + i / DATA_W)) begin
                    d.rdata[i % DATA_W] = posted_i[i];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign bus_rdata_o = q.rdata;
    assign mask_o      = q.mask;

    // R12: read data changes only after a read
    a_r12_rdata_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_valid_i && bus_rd_wrn_i) |=> $stable(bus_rdata_o));

endmodule

// File: rtl/irqc_post.sv
module irqc_post #(
    parameter int                 NUM_SRC   = 26,
    parameter int                 IDX_W     = 5,
    parameter logic [NUM_SRC-1:0] IMPL_MASK = irqc_pkg::IRQC_IMPL_DEFAULT
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] clr_i,
    input  logic               ack_i,
    input  logic [IDX_W-1:0]   ack_idx_i,
    output logic [NUM_SRC-1:0] posted_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] src_prev;
        logic [NUM_SRC-1:0] posted;
    } post_t;

    post_t q, d;

    logic [NUM_SRC-1:0] edge_w;
    logic [NUM_SRC-1:0] kill_w;
    logic [NUM_SRC-1:0] post_nxt;

    assign edge_w = src_i & ~q.src_prev;

    always_comb begin
        kill_w = clr_i;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (ack_i && ack_idx_i == IDX_W'(i)) kill_w[i] = 1'b1;
        end
    end

    // A slot either has a posting flop or is tied low.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
        if (IMPL_MASK[i]) begin : g_live
            assign post_nxt[i] = edge_w[i] | (q.posted[i] & ~kill_w[i]);
        end else begin : g_tied
            assign post_nxt[i] = 1'b0;
        end
    end

    always_comb begin
        d          = q;
        d.src_prev = src_i;
        d.posted   = post_nxt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign posted_o = q.posted;

    // R8: an acknowledged flag is gone next cycle unless re-posted
    a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && !edge_w[ack_idx_i]) |=> !posted_o[$past(ack_idx_i)]);

    // R11: a fresh edge always lands, whatever clears it in the same cycle
    a_r11_edge_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((edge_w & IMPL_MASK) != '0) |=>
        ((posted_o & $past(edge_w & IMPL_MASK)) == $past(edge_w & IMPL_MASK)));

    // R3: without any clear request, no posted flag falls (mask plays no part)
    a_r3_flags_persist: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ack_i && clr_i == '0) |=> ((posted_o & $past(posted_o)) == $past(posted_o)));

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int NUM_SRC = 26,
    parameter int IDX_W   = 5
) (
    input  logic [NUM_SRC-1:0] pend_i,
    output logic               hit_o,
    output logic [IDX_W-1:0]   idx_o
);

    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                hit_o = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int                 NUM_SRC   = 26,
    parameter int                 IDX_W     = 5,
    parameter int                 VEC_W     = 16,
    parameter int                 ADDR_W    = 4,
    parameter int                 DATA_W    = 8,
    parameter logic [NUM_SRC-1:0] IMPL_MASK = IRQC_IMPL_DEFAULT
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               gie_i,
    input  logic               irq_ack_i,
    output logic               irq_req_o,
    output logic [VEC_W-1:0]   irq_vec_o,
    output logic [IDX_W-1:0]   irq_idx_o,
    input  logic               bus_valid_i,
    input  logic               bus_rd_wrn_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [DATA_W-1:0]  bus_wdata_i,
    output logic [DATA_W-1:0]  bus_rdata_o
);

    localparam int VEC_SHIFT = 2;

    logic [NUM_SRC-1:0] posted_w;
    logic [NUM_SRC-1:0] mask_w;
    logic [NUM_SRC-1:0] clr_w;
    logic [NUM_SRC-1:0] pend_w;
    logic               hit_w;
    logic [IDX_W-1:0]   sel_w;
    logic               ack_w;

    irqc_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) i_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .bus_valid_i  (bus_valid_i),
        .bus_rd_wrn_i (bus_rd_wrn_i),
        .bus_addr_i   (bus_addr_i),
        .bus_wdata_i  (bus_wdata_i),
        .posted_i     (posted_w),
        .bus_rdata_o  (bus_rdata_o),
        .mask_o       (mask_w),
        .clr_o        (clr_w)
    );

    irqc_post #(
        .NUM_SRC   (NUM_SRC),
        .IDX_W     (IDX_W),
        .IMPL_MASK (IMPL_MASK)
    ) i_post (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .src_i     (src_i),
        .clr_i     (clr_w),
        .ack_i     (ack_w),
        .ack_idx_i (sel_w),
        .posted_o  (posted_w)
    );

    assign pend_w = posted_w & mask_w;

    irqc_prio #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) i_prio (
        .pend_i (pend_w),
        .hit_o  (hit_w),
        .idx_o  (sel_w)
    );

    always_comb begin
        irq_req_o = gie_i & hit_w;
        irq_idx_o = irq_req_o ? sel_w : '0;
        irq_vec_o = irq_req_o ? VEC_W'({sel_w, {VEC_SHIFT{1'b0}}}) : '0;
    end

    assign ack_w = irq_ack_i & irq_req_o;

    // R5: the presented source is pending and nothing above it is
    a_r5_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_req_o |-> (pend_w[irq_idx_o] &&
                       ((pend_w & ((NUM_SRC'(1) << irq_idx_o) - NUM_SRC'(1))) == '0)));

    // R7: a request never comes from a slot without a source
    a_r7_live_slot_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_req_o |-> IMPL_MASK[irq_idx_o]);

    // R4: without a pending source there is no request
    a_r4_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_w == '0) |-> !irq_req_o);

endmodule

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;

    localparam logic [25:0] LIVE = 26'h21660FA; // slots 1,3-7,13,14,17,18,20,25

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic [25:0] src = '0;
    logic        gie = 1'b0, ack = 1'b0;
    logic        valid = 1'b0, rd_wrn = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic [4:0]  irq_idx;
    logic [7:0]  rdata;

    int n_tests = 0, n_fail = 0;

    // reference state
    logic [25:0] m_posted = '0, m_mask = '0, m_prev = '0;
    logic [7:0]  m_rdata = '0;

    always #10 clk = ~clk;

    prio_irq_ctrl i_prio_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_ni), .src_i(src), .gie_i(gie), .irq_ack_i(ack),
        .irq_req_o(irq_req), .irq_vec_o(irq_vec), .irq_idx_o(irq_idx),
        .bus_valid_i(valid), .bus_rd_wrn_i(rd_wrn), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] lowest(logic [25:0] v);
        for (int i = 0; i < 26; i++) if (v[i]) return 5'(i);
        return 5'd0;
    endfunction

    // Check outputs against the model, then advance both by one clock.
    task automatic step(string tag);
        logic        e_req;
        logic [4:0]  e_idx;
        logic [25:0] clr, nxt_mask;
        logic [7:0]  nxt_rd;
        #2;
        e_req = gie && ((m_posted & m_mask) != '0);
        e_idx = e_req ? lowest(m_posted & m_mask) : 5'd0;
        chk({tag, " irq_req"}, 32'(irq_req), 32'(e_req));
        chk({tag, " irq_idx"}, 32'(irq_idx), 32'(e_idx));
        chk({tag, " irq_vec"}, 32'(irq_vec), 32'(e_idx) * 4);
        chk({tag, " rdata"},   32'(rdata),   32'(m_rdata));
        clr = '0; nxt_mask = m_mask; nxt_rd = m_rdata;
        if (valid && !rd_wrn) begin
            for (int i = 0; i < 26; i++) begin
                if (addr == 4'(i / 8)) nxt_mask[i] = wdata[i % 8];
                if (addr == 4'(4 + i / 8) && wdata[i % 8]) clr[i] = 1'b1;
            end
            if (addr == 4'd8) clr = '1;
        end
        if (valid && rd_wrn) begin
            nxt_rd = '0;
            for (int i = 0; i < 26; i++) begin
                if (addr == 4'(i / 8))     nxt_rd[i % 8] = m_mask[i];
                if (addr == 4'(4 + i / 8)) nxt_rd[i % 8] = m_posted[i];
            end
        end
        if (ack && e_req) clr[e_idx] = 1'b1;
        @(posedge clk);
        m_posted = ((m_posted & ~clr) | (src & ~m_prev)) & LIVE;
        m_mask   = nxt_mask;
        m_rdata  = nxt_rd;
        m_prev   = src;
        @(negedge clk);
    endtask

    task automatic idle();
        valid = 1'b0; ack = 1'b0; rd_wrn = 1'b0; addr = '0; wdata = '0;
    endtask

    task automatic bus_wr(logic [3:0] a, logic [7:0] v, string tag);
        idle(); valid = 1'b1; rd_wrn = 1'b0; addr = a; wdata = v;
        step(tag); idle();
    endtask

    task automatic bus_rd(logic [3:0] a, string tag);
        idle(); valid = 1'b1; rd_wrn = 1'b1; addr = a;
        step(tag); idle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        // R13: everything clear after reset
        step("R13 reset");
        chk("R13 reset irq_req", 32'(irq_req), 0);
        bus_rd(4'd0, "R13 mask read");
        step("R13 mask value");

        // R12: mask write and readback, one-cycle read latency
        bus_wr(4'd0, 8'hFF, "R12 mask0 wr");
        bus_wr(4'd1, 8'hFF, "R12 mask1 wr");
        bus_wr(4'd2, 8'hFF, "R12 mask2 wr");
        bus_wr(4'd3, 8'h03, "R12 mask3 wr");
        bus_rd(4'd3, "R12 mask3 rd");
        chk("R12 mask3 readback", 32'(rdata), 32'h03);

        // R1 / R6: single source posts and vectors
        gie = 1'b1;
        src[5] = 1'b1; step("R1 post src5");
        chk("R6 vector for index 5", 32'(irq_vec), 32'h14);
        chk("R1 request up", 32'(irq_req), 1);

        // R5: two higher-priority sources together
        src[3] = 1'b1; src[13] = 1'b1; step("R5 two edges");
        chk("R5 index 3 wins", 32'(irq_idx), 3);

        // R8: acknowledge removes index 3, index 5 follows
        ack = 1'b1; step("R8 ack"); idle();
        chk("R8 next index", 32'(irq_idx), 5);
        src[3] = 1'b0; src[5] = 1'b0; step("R8 drop lines");

        // R3: masking keeps posted flags
        bus_wr(4'd0, 8'h00, "R3 mask0 off");
        chk("R3 masked source 5 not chosen", 32'(irq_idx), 13);
        bus_rd(4'd4, "R3 status0 rd");
        chk("R3 posted kept under mask", 32'(rdata), 32'h20);
        src[6] = 1'b1; step("R3 post while masked");
        bus_rd(4'd4, "R3 status0 rd2");
        chk("R3 masked source still posts", 32'(rdata), 32'h60);

        // R9: zero bits ignored, one bits clear
        bus_wr(4'd4, 8'h00, "R9 clear none");
        bus_rd(4'd4, "R9 rd");
        chk("R9 zero write ignored", 32'(rdata), 32'h60);
        bus_wr(4'd4, 8'h20, "R9 clear bit5");
        bus_rd(4'd4, "R9 rd2");
        chk("R9 bit5 cleared", 32'(rdata), 32'h40);

        // R2: held-high source 13 does not re-post after clearing
        bus_wr(4'd5, 8'h20, "R2 clear 13");
        step("R2 hold"); step("R2 hold");
        bus_rd(4'd5, "R2 rd");
        chk("R2 no repost while held", 32'(rdata), 32'h00);

        // R11: edge on 14 in the same cycle as its clear
        idle(); src[14] = 1'b1; valid = 1'b1; addr = 4'd5; wdata = 8'h40;
        step("R11 edge+clear"); idle();
        bus_rd(4'd5, "R11 rd");
        chk("R11 edge beats clear", 32'(rdata), 32'h40);

        // R7: sources on reserved slots never post
        bus_wr(4'd0, 8'hFF, "R7 mask0 on");
        src[2] = 1'b1; src[0] = 1'b1; src[12:8] = '1; src[24:21] = '1;
        step("R7 reserved edges");
        bus_rd(4'd4, "R7 rd0");
        chk("R7 reserved byte0", 32'(rdata), 32'h40);
        bus_rd(4'd6, "R7 rd2");
        chk("R7 reserved byte2", 32'(rdata), 32'h00);

        // R4: global enable off hides the request
        gie = 1'b0; step("R4 gie low");
        chk("R4 no request", 32'(irq_req), 0);
        chk("R4 index zero", 32'(irq_idx), 0);
        gie = 1'b1;

        // R10: clear-all
        bus_wr(4'd8, 8'h00, "R10 clear all");
        chk("R10 no request", 32'(irq_req), 0);
        bus_rd(4'd5, "R10 rd");
        chk("R10 status empty", 32'(rdata), 0);

        // mixed random traffic against the model (R1-R12 together)
        void'($urandom(32'h5EED1));
        for (int n = 0; n < 4000; n++) begin
            int r;
            idle();
            src = src ^ (26'($urandom) & 26'($urandom) & 26'($urandom));
            gie = ($urandom % 8) != 0;
            ack = ($urandom % 3) == 0;
            r = $urandom % 100;
            if (r < 15) begin
                valid = 1'b1; rd_wrn = 1'b0; addr = 4'($urandom % 4); wdata = 8'($urandom);
            end else if (r < 25) begin
                valid = 1'b1; rd_wrn = 1'b0; addr = 4'(4 + $urandom % 4); wdata = 8'($urandom);
            end else if (r < 27) begin
                valid = 1'b1; rd_wrn = 1'b0; addr = 4'd8; wdata = 8'($urandom);
            end else if (r < 60) begin
                valid = 1'b1; rd_wrn = 1'b1; addr = 4'($urandom % 10);
            end
            step("R5 R8 R11 random");
        end
        idle();
        step("R12 final");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule